// File: doc/BRIEF.md
# Dual Lookup Table Slice with Memory and Shift Modes

The block holds two 16-entry, 1-bit-wide tables, called A and B. A configuration load fills one table's contents and chooses what that table does. In function mode the table is a fixed truth table: its four address inputs select one entry, so it can produce any Boolean function of four inputs. In memory mode the table is a 16x1 RAM. Writes happen on the clock edge and reads are combinational. In shift mode the table is a 16-bit shift register. The address picks which tap drives the output, which gives a delay line of adjustable length.

When both tables are in memory mode, a join setting can combine them into one larger memory. The three joined forms are a 32x1 RAM that uses a fifth address bit, a 16x2 RAM with one shared address, and a 16x1 dual-port RAM with a second read-only address. The joined result appears on a separate combined output. Surrounding routing, carry logic and flip-flops belong to the enclosing fabric.

Top module: `lut_slice`

## Requirements
- R1: After reset every table entry is 0, both tables are in function mode and the join setting is none. out_a, out_b and out_join therefore read 0.
- R2: A cycle with cfg_load high changes the table picked by cfg_slot (0 = A, 1 = B). On that edge:
  - the table takes cfg_truth, with bit i holding entry i;
  - the table takes cfg_mode: 0 = function, 1 = memory, 2 = shift, and 3 behaves as function;
  - the slice latches cfg_join: 0 = none, 1 = deep 32x1, 2 = wide 16x2, 3 = dual-port.
  The load overrides any write or shift requested on the same edge.
- R3: In function mode, out_a equals entry addr_a of table A and out_b equals entry addr_b of table B.
- R4: In function mode, we_a, we_b, din_a and din_b have no effect on the table contents.
- R5: When a table is in memory mode and no join is active, a clock edge with its write enable high stores its din at its address. Other entries keep their values.
- R6: Reads are combinational: a new address shows its entry on the output in the same cycle, with no clock edge needed.
- R7: In shift mode, each clock edge with the table's write enable high moves entry i to entry i+1, drops entry 15 and loads din into entry 0. The address picks the tap shown on the output.
- R8: A join is active only when both tables are in memory mode.
  - Deep join: the address is {addr_hi, addr_a}, and addr_hi = 0 selects table A. A write uses we_a and din_a.
  - out_join shows the addressed bit; out_a shows A[addr_a] and out_b shows B[addr_a].
- R9: Wide join: addr_a addresses both tables. we_a writes din_a into A and din_b into B at that address. out_a and out_b show the two bits, and out_join equals out_a.
- R10: Dual-port join: we_a writes din_a into both tables at addr_a, and out_a shows A[addr_a]. out_b and out_join show B[addr_b].
- R11: While a join is active, we_b does not write. While no join is active, out_join is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load configuration into the selected table |
| cfg_slot | input | 1 | Table selected by a load (0 = A, 1 = B) |
| cfg_mode | input | 2 | Mode for the selected table |
| cfg_join | input | 2 | Join setting latched on every load |
| cfg_truth | input | DEPTH | Initial contents for the selected table |
| addr_a | input | AW | Table A address, function inputs or tap |
| addr_b | input | AW | Table B address, function inputs, tap or read-only address |
| addr_hi | input | 1 | Fifth address bit for the deep join |
| din_a | input | 1 | Write or shift data for table A |
| din_b | input | 1 | Write or shift data for table B |
| we_a | input | 1 | Write or shift enable for table A, and for the joined memory |
| we_b | input | 1 | Write or shift enable for table B |
| out_a | output | 1 | Table A read |
| out_b | output | 1 | Table B read |
| out_join | output | 1 | Combined output of the joined memory |

## Verification
The hardest situation to set up is a join that is latched but not in force. It happens when the join setting says dual-port while one table has since been reloaded into function mode. The stimulus first fills table B through the dual-port write path. It then reloads only table A as a function table, keeping join code 3. This shows that out_join drops to 0 while out_b goes back to separate reads of B. A second hard case is a load that coincides with a write strobe. The bench holds we_a high during the load cycle and then checks that the loaded contents win.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;

    typedef enum logic [1:0] {
        LM_FUNC  = 2'd0,
        LM_RAM   = 2'd1,
        LM_SHIFT = 2'd2,
        LM_RSVD  = 2'd3
    } lut_mode_e;

    typedef enum logic [1:0] {
        JN_NONE = 2'd0,
        JN_DEEP = 2'd1,
        JN_WIDE = 2'd2,
        JN_DUAL = 2'd3
    } join_e;

endpackage

// File: rtl/lut_table_core.sv
module lut_table_core
    import lut_slice_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [1:0]       cfg_mode,
    input  logic [DEPTH-1:0] cfg_truth,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic             wr_bit,
    input  logic             sh_en,
    input  logic             sh_bit,
    input  logic [AW-1:0]    rd_addr,
    output logic [DEPTH-1:0] bits_q,
    output lut_mode_e        mode_q,
    output logic             rd_bit
);

    typedef struct packed {
        logic [DEPTH-1:0] bits;
        lut_mode_e        mode;
    } tbl_st_t;

    tbl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_load) begin
            st_d.bits = cfg_truth;
            st_d.mode = (cfg_mode == LM_RSVD) ? LM_FUNC : lut_mode_e'(cfg_mode);
        end else begin
            case (st_q.mode)
                LM_RAM: begin
                    if (wr_en) begin
                        st_d.bits[wr_addr] = wr_bit;
                    end
                end
                LM_SHIFT: begin
                    if (sh_en) begin
                        st_d.bits = {st_q.bits[DEPTH-2:0], sh_bit};
                    end
                end
                default: begin
                    st_d = st_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bits: '0, mode: LM_FUNC};
        end else begin
            st_q <= st_d;
        end
    end

    assign bits_q = st_q.bits;
    assign mode_q = st_q.mode;
    assign rd_bit = st_q.bits[rd_addr];

endmodule

// File: rtl/lut_join_ctrl.sv
module lut_join_ctrl
    import lut_slice_pkg::*;
#(
    parameter int AW = 4
) (
    input  lut_mode_e   mode_a,
    input  lut_mode_e   mode_b,
    input  join_e       join_q,
    input  logic [AW-1:0] addr_a,
    input  logic [AW-1:0] addr_b,
    input  logic        addr_hi,
    input  logic        din_a,
    input  logic        din_b,
    input  logic        we_a,
    input  logic        we_b,
    output join_e       eff_join,
    output logic [1:0]  wr_en,
    output logic [1:0]  wr_bit,
    output logic [1:0]  sh_en,
    output logic [1:0]  sh_bit,
    output logic [AW-1:0] wr_addr [2],
    output logic [AW-1:0] rd_addr [2]
);

    always_comb begin
        eff_join   = (mode_a == LM_RAM && mode_b == LM_RAM) ? join_q : JN_NONE;
        wr_en      = {we_b, we_a};
        wr_bit     = {din_b, din_a};
        sh_en      = {we_b, we_a};
        sh_bit     = {din_b, din_a};
        wr_addr[0] = addr_a;
        wr_addr[1] = addr_b;
        rd_addr[0] = addr_a;
        rd_addr[1] = addr_b;
        case (eff_join)
            JN_DEEP: begin
                wr_en      = {we_a & addr_hi, we_a & ~addr_hi};
                wr_bit     = {din_a, din_a};
                wr_addr[1] = addr_a;
                rd_addr[1] = addr_a;
            end
            JN_WIDE: begin
                wr_en      = {we_a, we_a};
                wr_addr[1] = addr_a;
                rd_addr[1] = addr_a;
            end
            JN_DUAL: begin
                wr_en      = {we_a, we_a};
                wr_bit     = {din_a, din_a};
                wr_addr[1] = addr_a;
            end
            default: begin
                wr_en = {we_b, we_a};
            end
        endcase
    end

endmodule

// File: rtl/lut_out_mux.sv
module lut_out_mux
    import lut_slice_pkg::*;
(
    input  join_e      eff_join,
    input  logic [1:0] rd_bit,
    input  logic       addr_hi,
    output logic       out_a,
    output logic       out_b,
    output logic       out_join
);

    always_comb begin
        out_a = rd_bit[0];
        out_b = rd_bit[1];
        case (eff_join)
            JN_DEEP: out_join = addr_hi ? rd_bit[1] : rd_bit[0];
            JN_WIDE: out_join = rd_bit[0];
            JN_DUAL: out_join = rd_bit[1];
            default: out_join = 1'b0;
        endcase
    end

endmodule

// File: rtl/lut_slice.sv
module lut_slice
    import lut_slice_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_slot,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_join,
    input  logic [DEPTH-1:0] cfg_truth,
    input  logic [AW-1:0]    addr_a,
    input  logic [AW-1:0]    addr_b,
    input  logic             addr_hi,
    input  logic             din_a,
    input  logic             din_b,
    input  logic             we_a,
    input  logic             we_b,
    output logic             out_a,
    output logic             out_b,
    output logic             out_join
);

    typedef struct packed {
        join_e jn;
    } slice_st_t;

    slice_st_t st_d, st_q;

    logic [DEPTH-1:0] tbl_q   [2];
    lut_mode_e        tbl_mode [2];
    logic [1:0]       rd_bit;
    join_e            eff_join;
    logic [1:0]       wr_en, wr_bit, sh_en, sh_bit;
    logic [AW-1:0]    wr_addr [2];
    logic [AW-1:0]    rd_addr [2];

    always_comb begin
        st_d = st_q;
        if (cfg_load) begin
            st_d.jn = join_e'(cfg_join);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{jn: JN_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    lut_join_ctrl #(.AW(AW)) u_join (
        .mode_a  (tbl_mode[0]),
        .mode_b  (tbl_mode[1]),
        .join_q  (st_q.jn),
        .addr_a  (addr_a),
        .addr_b  (addr_b),
        .addr_hi (addr_hi),
        .din_a   (din_a),
        .din_b   (din_b),
        .we_a    (we_a),
        .we_b    (we_b),
        .eff_join(eff_join),
        .wr_en   (wr_en),
        .wr_bit  (wr_bit),
        .sh_en   (sh_en),
        .sh_bit  (sh_bit),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr)
    );

    for (genvar g = 0; g < 2; g++) begin : g_tbl
        lut_table_core #(.DEPTH(DEPTH)) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_load (cfg_load && (cfg_slot == 1'(g))),
            .cfg_mode (cfg_mode),
            .cfg_truth(cfg_truth),
            .wr_en    (wr_en[g]),
            .wr_addr  (wr_addr[g]),
            .wr_bit   (wr_bit[g]),
            .sh_en    (sh_en[g]),
            .sh_bit   (sh_bit[g]),
            .rd_addr  (rd_addr[g]),
            .bits_q   (tbl_q[g]),
            .mode_q   (tbl_mode[g]),
            .rd_bit   (rd_bit[g])
        );
    end

    lut_out_mux u_out (
        .eff_join(eff_join),
        .rd_bit  (rd_bit),
        .addr_hi (addr_hi),
        .out_a   (out_a),
        .out_b   (out_b),
        .out_join(out_join)
    );

endmodule

// File: rtl/lut_slice_chk.sv
module lut_slice_chk #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_load,
    input logic             cfg_slot,
    input logic [DEPTH-1:0] cfg_truth,
    input logic [AW-1:0]    addr_a,
    input logic [AW-1:0]    addr_b,
    input logic             addr_hi,
    input logic             din_a,
    input logic             we_a,
    input logic             out_a,
    input logic             out_join,
    input logic [DEPTH-1:0] tbl_a,
    input logic [DEPTH-1:0] tbl_b,
    input logic [1:0]       mode_a,
    input logic [1:0]       mode_b,
    input logic [1:0]       join_q
);

    logic both_ram;
    assign both_ram = (mode_a == 2'd1) && (mode_b == 2'd1);

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load && !cfg_slot |=> tbl_a == $past(cfg_truth));

    // R3
    func_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_a == 2'd0 |-> out_a == tbl_a[addr_a]);

    // R4
    func_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_a == 2'd0 && !cfg_load |=> tbl_a == $past(tbl_a));

    // R5
    ram_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_a == 2'd1 && (!both_ram || join_q == 2'd0) && we_a && !cfg_load
        |=> tbl_a[$past(addr_a)] == $past(din_a));

    // R7
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_a == 2'd2 && we_a && !cfg_load
        |=> tbl_a == {$past(tbl_a[DEPTH-2:0]), $past(din_a)});

    // R8
    deep_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        both_ram && join_q == 2'd1
        |-> out_join == (addr_hi ? tbl_b[addr_a] : tbl_a[addr_a]));

    // R10
    dual_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        both_ram && join_q == 2'd3 |-> out_join == tbl_b[addr_b]);

    // R11
    join_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(both_ram && join_q != 2'd0) |-> out_join == 1'b0);

endmodule

bind lut_slice lut_slice_chk #(.DEPTH(DEPTH)) u_lut_slice_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .cfg_slot (cfg_slot),
    .cfg_truth(cfg_truth),
    .addr_a   (addr_a),
    .addr_b   (addr_b),
    .addr_hi  (addr_hi),
    .din_a    (din_a),
    .we_a     (we_a),
    .out_a    (out_a),
    .out_join (out_join),
    .tbl_a    (tbl_q[0]),
    .tbl_b    (tbl_q[1]),
    .mode_a   (tbl_mode[0]),
    .mode_b   (tbl_mode[1]),
    .join_q   (st_q.jn)
);

// File: tb/lut_slice_bench.sv
module lut_slice_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic        cfg_slot = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [1:0]  cfg_join = 2'd0;
    logic [15:0] cfg_truth = '0;
    logic [3:0]  addr_a = '0;
    logic [3:0]  addr_b = '0;
    logic        addr_hi = 1'b0;
    logic        din_a = 1'b0;
    logic        din_b = 1'b0;
    logic        we_a = 1'b0;
    logic        we_b = 1'b0;
    logic        out_a, out_b, out_join;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    lut_slice u_lut_slice (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_slot(cfg_slot),
        .cfg_mode(cfg_mode), .cfg_join(cfg_join), .cfg_truth(cfg_truth),
        .addr_a(addr_a), .addr_b(addr_b), .addr_hi(addr_hi),
        .din_a(din_a), .din_b(din_b), .we_a(we_a), .we_b(we_b),
        .out_a(out_a), .out_b(out_b), .out_join(out_join)
    );

    // {addr_a, addr_b, expected out_a (parity), expected out_b (4-input AND)}
    localparam logic [9:0] FN_VEC [8] = '{
        {4'd0,  4'd0,  1'b0, 1'b0},
        {4'd1,  4'd15, 1'b1, 1'b1},
        {4'd3,  4'd7,  1'b0, 1'b0},
        {4'd7,  4'd14, 1'b1, 1'b0},
        {4'd15, 4'd15, 1'b0, 1'b1},
        {4'd8,  4'd3,  1'b1, 1'b0},
        {4'd5,  4'd12, 1'b0, 1'b0},
        {4'd14, 4'd15, 1'b1, 1'b1}
    };

    task automatic check(input logic got, input logic exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic load(input logic slot, input logic [15:0] truth,
                        input logic [1:0] mode, input logic [1:0] jn);
        @(negedge clk);
        cfg_load = 1'b1; cfg_slot = slot; cfg_truth = truth;
        cfg_mode = mode; cfg_join = jn;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic edge_then_clear();
        @(negedge clk);
        we_a = 1'b0; we_b = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_a, 1'b0, "R1 out_a");
        check(out_b, 1'b0, "R1 out_b");
        check(out_join, 1'b0, "R1 out_join");
        rst_n = 1'b1;
        addr_a = 4'd9; addr_b = 4'd12; #1;
        check(out_a, 1'b0, "R1 cleared A");

        // R2, R3: function tables driven from the vector list
        load(1'b0, 16'h6996, 2'd0, 2'd0);
        load(1'b1, 16'h8000, 2'd3, 2'd0);
        foreach (FN_VEC[i]) begin
            addr_a = FN_VEC[i][9:6]; addr_b = FN_VEC[i][5:2]; #1;
            check(out_a, FN_VEC[i][1], "R3 parity");
            check(out_b, FN_VEC[i][0], "R3 and4");
        end

        // R4: write and shift strobes ignored in function mode
        @(negedge clk);
        addr_a = 4'd0; addr_b = 4'd0; din_a = 1'b1; din_b = 1'b1;
        we_a = 1'b1; we_b = 1'b1;
        edge_then_clear();
        #1;
        check(out_a, 1'b0, "R4 A unchanged");
        check(out_b, 1'b0, "R4 B unchanged");

        // R5, R6: separate RAM
        load(1'b0, 16'h0000, 2'd1, 2'd0);
        addr_a = 4'd5; din_a = 1'b1; we_a = 1'b1;
        edge_then_clear();
        addr_a = 4'd4; #1;
        check(out_a, 1'b0, "R5 neighbour");
        addr_a = 4'd5; #1;
        check(out_a, 1'b1, "R6 same-cycle read");
        addr_a = 4'd4; #1;
        check(out_a, 1'b0, "R6 address change");

        // R7: shift register on B
        load(1'b1, 16'h0000, 2'd2, 2'd0);
        foreach (FN_VEC[i]) begin
            if (i < 4) begin
                din_b = (i == 1) ? 1'b0 : 1'b1; we_b = 1'b1;
                edge_then_clear();
            end
        end
        addr_b = 4'd0; #1; check(out_b, 1'b1, "R7 tap0");
        addr_b = 4'd1; #1; check(out_b, 1'b1, "R7 tap1");
        addr_b = 4'd2; #1; check(out_b, 1'b0, "R7 tap2");
        addr_b = 4'd3; #1; check(out_b, 1'b1, "R7 tap3");
        addr_b = 4'd4; #1; check(out_b, 1'b0, "R7 tap4");

        // R8, R11: deep join
        load(1'b0, 16'h0000, 2'd1, 2'd1);
        load(1'b1, 16'h0000, 2'd1, 2'd1);
        addr_a = 4'd3; addr_hi = 1'b1; din_a = 1'b1; we_a = 1'b1;
        edge_then_clear();
        #1;
        check(out_join, 1'b1, "R8 upper half");
        check(out_b, 1'b1, "R8 out_b");
        check(out_a, 1'b0, "R8 out_a");
        addr_hi = 1'b0; #1;
        check(out_join, 1'b0, "R8 lower half");
        addr_b = 4'd7; din_b = 1'b1; we_b = 1'b1;
        edge_then_clear();
        addr_a = 4'd7; addr_hi = 1'b1; #1;
        check(out_join, 1'b0, "R11 we_b ignored deep");

        // R9: wide join
        load(1'b0, 16'h0000, 2'd1, 2'd2);
        load(1'b1, 16'h0000, 2'd1, 2'd2);
        addr_a = 4'd9; din_a = 1'b1; din_b = 1'b0; we_a = 1'b1;
        edge_then_clear();
        addr_a = 4'd10; din_a = 1'b0; din_b = 1'b1; we_a = 1'b1;
        edge_then_clear();
        addr_a = 4'd9; #1;
        check(out_a, 1'b1, "R9 low bit @9");
        check(out_b, 1'b0, "R9 high bit @9");
        check(out_join, 1'b1, "R9 join @9");
        addr_a = 4'd10; #1;
        check(out_a, 1'b0, "R9 low bit @10");
        check(out_b, 1'b1, "R9 high bit @10");

        // R10: dual-port join
        load(1'b0, 16'h0000, 2'd1, 2'd3);
        load(1'b1, 16'h0000, 2'd1, 2'd3);
        addr_a = 4'd6; din_a = 1'b1; we_a = 1'b1;
        edge_then_clear();
        addr_b = 4'd6; #1;
        check(out_a, 1'b1, "R10 port A");
        check(out_b, 1'b1, "R10 read port");
        check(out_join, 1'b1, "R10 join");
        addr_b = 4'd7; #1;
        check(out_join, 1'b0, "R10 other address");
        addr_b = 4'd2; din_b = 1'b1; we_b = 1'b1;
        edge_then_clear();
        #1;
        check(out_b, 1'b0, "R11 we_b ignored dual");

        // R11: join latched but inactive once A is back in function mode
        load(1'b0, 16'h0000, 2'd0, 2'd3);
        addr_b = 4'd6; #1;
        check(out_join, 1'b0, "R11 idle join");
        check(out_b, 1'b1, "R11 separate B read");

        // R2: load wins over a write strobe on the same edge
        @(negedge clk);
        cfg_load = 1'b1; cfg_slot = 1'b0; cfg_truth = 16'h0001;
        cfg_mode = 2'd1; cfg_join = 2'd0;
        addr_a = 4'd0; din_a = 1'b0; we_a = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0; we_a = 1'b0; #1;
        check(out_a, 1'b1, "R2 load priority");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule